// File: doc/BRIEF.md
# SDRAM Device-Side Command Front End

This block sits at the pin boundary of a four-bank single-data-rate SDRAM and turns the sampled control pins into commands. On every rising clock edge it reads chip select, the three command strobes, clock enable, the bank select and the thirteen-bit address. It then decodes one of activate, read, write, precharge, auto-refresh, mode load, burst stop, no-op or deselect. Each accepted command becomes a one-cycle strobe. The block also latches the bank, row and column that go with the command.

Per bank it keeps an open or idle bit and the row that is open. Commands that break the bank rules are refused and raise a one-cycle illegal flag. A mode load writes a small mode register and opens a short busy window. Clock enable low freezes all state from the following edge on. When every bank is idle at that point, the block also reports power-down. The array, the data path, burst counting and refresh timing live in other blocks. There is no data stream at this interface, so every pin is plain control or status.

Top module: `sdram_cmd_front`

## Requirements
- R1: After reset all banks are idle, all strobes and flags are 0, the latched bank/row/column are 0 and all mode fields are 0.
- R2: With cs_n low, the pin code {ras_n,cas_n,we_n} decodes as 011 activate, 101 read, 100 write, 010 precharge, 001 auto-refresh and 000 mode load. Each accepted command gives exactly one strobe, high for the one cycle after the sampling edge.
- R3: cs_n high (deselect), code 111 (no-op) and code 110 (burst stop) change no state, give no strobe and never raise the illegal flag.
- R4: Activate on an idle bank latches bank and row (addr[12:0]) and marks that bank open.
- R5: Read or write on an open bank latches the bank and the column addr[8:0]. It also sets the latched row to that bank's open row.
- R6: Precharge with addr[10]=1 closes all banks. With addr[10]=0 it closes only the selected bank. Precharging an idle bank is legal.
- R7: An accepted mode load sets burst length = addr[2:0], burst type = addr[3], CAS latency = addr[6:4] and write single = addr[9]. Non-standard is set to the OR of addr[8:7], addr[12:10] and ba.
- R8: For one cycle after an accepted mode load, mr_busy is 1. Activate, read, write, precharge, refresh or mode load sampled on the next edge is refused as illegal. Commands on the second edge after the load are accepted.
- R9: The illegal flag pulses, and nothing changes, for any of these: activate to an open bank, read or write to an idle bank, or refresh or mode load while any bank is open.
- R10: A command on the edge where cke is first sampled low still executes. On later edges while cke stays low, inputs are ignored and all state and outputs hold. The edge where cke is sampled high again accepts its command.
- R11: suspended shows cke was low at the last edge. power_down is 1 when cke was low at the last edge and all banks were idle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge samples all pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 13 | Multiplexed row/column/mode address |
| cmd_act | output | 1 | Activate strobe |
| cmd_rd | output | 1 | Read strobe |
| cmd_wr | output | 1 | Write strobe |
| cmd_pre | output | 1 | Precharge strobe |
| cmd_ref | output | 1 | Auto-refresh strobe |
| cmd_mrs | output | 1 | Mode load strobe |
| illegal | output | 1 | Refused-command pulse |
| bank_open | output | 4 | Open bit per bank |
| lat_bank | output | 2 | Latched bank |
| lat_row | output | 13 | Latched row |
| lat_col | output | 9 | Latched column |
| mr_burst_len | output | 3 | Burst length code |
| mr_burst_type | output | 1 | Burst type |
| mr_cas_lat | output | 3 | CAS latency code |
| mr_write_single | output | 1 | Write burst mode bit |
| mr_nonstd | output | 1 | Non-standard mode bits set |
| mr_busy | output | 1 | Mode load in progress |
| suspended | output | 1 | Clock suspended |
| power_down | output | 1 | Power-down state |

## Verification
A wrong open bit shows up within one cycle. The next activate, read or refresh to that bank gets the wrong strobe or illegal pulse, and bank_open shows the difference directly. A stale per-bank row stays hidden until a read or write to that bank, which then puts the wrong lat_row on the ports. Frozen-state faults under cke low show up on the first edge after cke is sampled high. The bench sweeps every pin code over every bank, from both the idle state and the open state. It compares all ports against an arithmetic model after every edge.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;
  typedef enum logic [3:0] {
    CMD_DESEL, CMD_NOP, CMD_BST, CMD_ACT, CMD_RD,
    CMD_WR, CMD_PRE, CMD_REF, CMD_MRS
  } cmd_e;

  typedef struct packed {
    logic [2:0] burst_len;
    logic       burst_type;
    logic [2:0] cas_lat;
    logic       write_single;
    logic       nonstd;
  } mode_t;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_cmd_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    if (cs_n) begin
      cmd = CMD_DESEL;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b111: cmd = CMD_NOP;
        3'b110: cmd = CMD_BST;
        3'b011: cmd = CMD_ACT;
        3'b101: cmd = CMD_RD;
        3'b100: cmd = CMD_WR;
        3'b010: cmd = CMD_PRE;
        3'b001: cmd = CMD_REF;
        default: cmd = CMD_MRS;
      endcase
    end
  end
endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
  import sdram_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  cmd_e                 cmd,
  input  logic [BA_W-1:0]      ba,
  input  logic                 pre_all,
  input  logic [ROW_W-1:0]     row_in,
  output logic [NUM_BANKS-1:0] open_q,
  output logic [NUM_BANKS-1:0] open_nxt,
  output logic [ROW_W-1:0]     row_sel
);
  logic [ROW_W-1:0] row_q [NUM_BANKS];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic hit;
    assign hit = (ba == BA_W'(g));

    always_comb begin
      open_nxt[g] = open_q[g];
      if (en && cmd == CMD_ACT && hit) open_nxt[g] = 1'b1;
      else if (en && cmd == CMD_PRE && (pre_all || hit)) open_nxt[g] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q[g] <= 1'b0;
        row_q[g]  <= '0;
      end else begin
        open_q[g] <= open_nxt[g];
        if (en && cmd == CMD_ACT && hit) row_q[g] <= row_in;
      end
    end
  end

  assign row_sel = row_q[ba];

  // R6: precharge with the all-banks bit leaves every bank idle
  a_r6_pre_all_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cmd == CMD_PRE && pre_all) |=> (open_q == '0));

  // R4: accepted activate opens the addressed bank
  a_r4_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cmd == CMD_ACT) |=> open_q[$past(ba)]);
endmodule

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg
  import sdram_cmd_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BA_W-1:0]   ba,
  output mode_t             mode,
  output logic              busy
);
  mode_t mode_d;
  always_comb begin
    mode_d.burst_len    = addr[2:0];
    mode_d.burst_type   = addr[3];
    mode_d.cas_lat      = addr[6:4];
    mode_d.write_single = addr[9];
    mode_d.nonstd       = |{addr[8:7], addr[ADDR_W-1:10], ba};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= '0;
      busy <= 1'b0;
    end else if (adv) begin
      busy <= load;
      if (load) mode <= mode_d;
    end
  end

  // R8: a load always opens the busy window
  a_r8_busy_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy);

  // R7: fields only change on a load
  a_r7_mode_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(mode));
endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
  import sdram_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 9,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cke,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BA_W-1:0]      ba,
  input  logic [ROW_W-1:0]     addr,
  output logic                 cmd_act,
  output logic                 cmd_rd,
  output logic                 cmd_wr,
  output logic                 cmd_pre,
  output logic                 cmd_ref,
  output logic                 cmd_mrs,
  output logic                 illegal,
  output logic [NUM_BANKS-1:0] bank_open,
  output logic [BA_W-1:0]      lat_bank,
  output logic [ROW_W-1:0]     lat_row,
  output logic [COL_W-1:0]     lat_col,
  output logic [2:0]           mr_burst_len,
  output logic                 mr_burst_type,
  output logic [2:0]           mr_cas_lat,
  output logic                 mr_write_single,
  output logic                 mr_nonstd,
  output logic                 mr_busy,
  output logic                 suspended,
  output logic                 power_down
);
  cmd_e                 cmd;
  logic                 cke_q;
  logic                 accept;
  logic                 bad;
  logic                 legal;
  logic                 active_cmd;
  logic [NUM_BANKS-1:0] open_nxt;
  logic [ROW_W-1:0]     row_sel;
  mode_t                mode;

  sdram_cmd_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
  );

  // edge accepted if cke high now (exit) or high at the previous edge
  assign accept = cke | cke_q;

  assign active_cmd = (cmd != CMD_DESEL) && (cmd != CMD_NOP) && (cmd != CMD_BST);

  always_comb begin
    bad = 1'b0;
    if (mr_busy && active_cmd) bad = 1'b1;
    unique case (cmd)
      CMD_ACT:         if (bank_open[ba]) bad = 1'b1;
      CMD_RD, CMD_WR:  if (!bank_open[ba]) bad = 1'b1;
      CMD_REF, CMD_MRS: if (|bank_open) bad = 1'b1;
      default: ;
    endcase
  end

  assign legal = accept & ~bad;

  sdram_bank_track #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_banks (
    .clk(clk), .rst_n(rst_n), .en(legal), .cmd(cmd), .ba(ba),
    .pre_all(addr[10]), .row_in(addr), .open_q(bank_open),
    .open_nxt(open_nxt), .row_sel(row_sel)
  );

  sdram_mode_reg #(.ADDR_W(ROW_W), .BA_W(BA_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .adv(accept), .load(legal && cmd == CMD_MRS),
    .addr(addr), .ba(ba), .mode(mode), .busy(mr_busy)
  );

  assign mr_burst_len    = mode.burst_len;
  assign mr_burst_type   = mode.burst_type;
  assign mr_cas_lat      = mode.cas_lat;
  assign mr_write_single = mode.write_single;
  assign mr_nonstd       = mode.nonstd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q      <= 1'b1;
      suspended  <= 1'b0;
      power_down <= 1'b0;
      cmd_act    <= 1'b0;
      cmd_rd     <= 1'b0;
      cmd_wr     <= 1'b0;
      cmd_pre    <= 1'b0;
      cmd_ref    <= 1'b0;
      cmd_mrs    <= 1'b0;
      illegal    <= 1'b0;
      lat_bank   <= '0;
      lat_row    <= '0;
      lat_col    <= '0;
    end else begin
      cke_q      <= cke;
      suspended  <= ~cke;
      power_down <= ~cke & ~|open_nxt;
      cmd_act    <= legal && cmd == CMD_ACT;
      cmd_rd     <= legal && cmd == CMD_RD;
      cmd_wr     <= legal && cmd == CMD_WR;
      cmd_pre    <= legal && cmd == CMD_PRE;
      cmd_ref    <= legal && cmd == CMD_REF;
      cmd_mrs    <= legal && cmd == CMD_MRS;
      illegal    <= accept & bad;
      if (legal) begin
        unique case (cmd)
          CMD_ACT: begin
            lat_bank <= ba;
            lat_row  <= addr;
          end
          CMD_RD, CMD_WR: begin
            lat_bank <= ba;
            lat_col  <= addr[COL_W-1:0];
            lat_row  <= row_sel;
          end
          CMD_PRE: lat_bank <= ba;
          default: ;
        endcase
      end
    end
  end

  // R2: at most one strobe per cycle
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_ref, cmd_mrs}));

  // R9: a refused command never strobes
  a_r9_refused_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !(cmd_act | cmd_rd | cmd_wr | cmd_pre | cmd_ref | cmd_mrs));

  // R5: column access only lands on an open bank
  a_r5_access_open: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rd | cmd_wr) |-> bank_open[lat_bank]);

  // R8: nothing is accepted on the edge after a mode load
  a_r8_gap_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_mrs |=> !(cmd_act | cmd_rd | cmd_wr | cmd_pre | cmd_ref | cmd_mrs));

  // R10: while cke stays low the state holds
  a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && !cke) |=> ($stable(bank_open) && $stable(lat_row) &&
      $stable(lat_col) && $stable(lat_bank) && $stable(mr_busy) && !illegal &&
      !(cmd_act | cmd_rd | cmd_wr | cmd_pre | cmd_ref | cmd_mrs)));

  // R11: power-down implies every bank idle
  a_r11_pd_idle: assert property (@(posedge clk) disable iff (!rst_n)
    power_down |-> (bank_open == '0) && suspended);
endmodule

// File: tb/sdram_cmd_front_bench.sv
module sdram_cmd_front_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [12:0] addr = '0;
  logic cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_ref, cmd_mrs, illegal;
  logic [3:0]  bank_open;
  logic [1:0]  lat_bank;
  logic [12:0] lat_row;
  logic [8:0]  lat_col;
  logic [2:0]  mr_burst_len, mr_cas_lat;
  logic mr_burst_type, mr_write_single, mr_nonstd, mr_busy, suspended, power_down;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_front u_sdram_cmd_front (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .cmd_act(cmd_act), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_pre(cmd_pre),
    .cmd_ref(cmd_ref), .cmd_mrs(cmd_mrs), .illegal(illegal),
    .bank_open(bank_open), .lat_bank(lat_bank), .lat_row(lat_row),
    .lat_col(lat_col), .mr_burst_len(mr_burst_len),
    .mr_burst_type(mr_burst_type), .mr_cas_lat(mr_cas_lat),
    .mr_write_single(mr_write_single), .mr_nonstd(mr_nonstd),
    .mr_busy(mr_busy), .suspended(suspended), .power_down(power_down)
  );

  int checks = 0;
  int fails  = 0;

  // model state
  logic [3:0]  m_open = '0;
  logic [12:0] m_row [4] = '{default: '0};
  logic        m_cke_q = 1'b1;
  logic        m_busy = 1'b0;
  logic [5:0]  e_strb = '0;
  logic        e_ill = 1'b0;
  logic [1:0]  e_bank = '0;
  logic [12:0] e_row = '0;
  logic [8:0]  e_col = '0;
  logic [8:0]  e_mr = '0;
  logic        e_susp = 1'b0, e_pd = 1'b0;

  function automatic logic [46:0] got_vec();
    return {cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_ref, cmd_mrs, illegal,
            bank_open, lat_bank, lat_row, lat_col, mr_burst_len,
            mr_burst_type, mr_cas_lat, mr_write_single, mr_nonstd,
            mr_busy, suspended, power_down};
  endfunction

  function automatic logic [46:0] exp_vec();
    return {e_strb, e_ill, m_open, e_bank, e_row, e_col, e_mr,
            m_busy, e_susp, e_pd};
  endfunction

  task automatic check(input string tag);
    checks++;
    if (got_vec() !== exp_vec()) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, got_vec(), exp_vec());
    end
  endtask

  // strobe order: act rd wr pre ref mrs
  task automatic step(input logic k, input logic c, input logic [2:0] code,
                      input logic [1:0] b, input logic [12:0] ad,
                      input string tag);
    logic acc, hit, anyo, act, busyblk;
    cke = k; cs_n = c; {ras_n, cas_n, we_n} = code; ba = b; addr = ad;
    @(posedge clk);
    acc = k | m_cke_q;
    e_strb = '0;
    e_ill = 1'b0;
    if (acc) begin
      hit = m_open[b];
      anyo = |m_open;
      act = !c && code != 3'b111 && code != 3'b110;
      busyblk = m_busy && act;
      if (!c) begin
        e_ill = busyblk
              | (code == 3'b011 && hit)
              | ((code == 3'b101 || code == 3'b100) && !hit)
              | ((code == 3'b001 || code == 3'b000) && anyo);
      end
      if (!c && !e_ill) begin
        case (code)
          3'b011: begin m_open[b] = 1'b1; m_row[b] = ad; e_bank = b; e_row = ad; e_strb[5] = 1'b1; end
          3'b101: begin e_bank = b; e_col = ad[8:0]; e_row = m_row[b]; e_strb[4] = 1'b1; end
          3'b100: begin e_bank = b; e_col = ad[8:0]; e_row = m_row[b]; e_strb[3] = 1'b1; end
          3'b010: begin
            e_bank = b; e_strb[2] = 1'b1;
            if (ad[10]) m_open = '0; else m_open[b] = 1'b0;
          end
          3'b001: e_strb[1] = 1'b1;
          3'b000: begin
            e_strb[0] = 1'b1;
            e_mr = {ad[2:0], ad[3], ad[6:4], ad[9], |{ad[8:7], ad[12:10], b}};
          end
          default: ;
        endcase
      end
      m_busy = e_strb[0];
    end
    m_cke_q = k;
    e_susp = !k;
    e_pd = !k && (m_open == '0);
    @(negedge clk);
    check(tag);
  endtask

  task automatic nop(input string tag);
    step(1'b1, 1'b0, 3'b111, 2'd0, 13'h0, tag);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hang expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  string tags [8] = '{"R7/R9", "R2/R9", "R6", "R4/R9", "R5/R9", "R5/R9", "R3", "R3"};

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1");

    // sweep: every pin code, every bank, from idle and from open
    for (int init = 0; init < 2; init++) begin
      for (int code = 0; code < 8; code++) begin
        for (int b = 0; b < 4; b++) begin
          logic [12:0] ad;
          nop("R3");
          step(1'b1, 1'b0, 3'b010, 2'd0, 13'h400, "R6");
          if (init == 1) step(1'b1, 1'b0, 3'b011, 2'(b), 13'(b * 97 + code * 5 + 1), "R4");
          ad = 13'((code * 291 + b * 81 + init * 1024) % 8192);
          step(1'b1, 1'b0, 3'(code), 2'(b), ad, tags[code]);
          // immediately after: tests the mode-load gap (R8)
          step(1'b1, 1'b0, 3'b011, 2'((b + 1) % 4), 13'h0A5, "R8");
          nop("R2");
        end
      end
    end

    // deselect with arbitrary pins
    for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 3'(i), 2'(i % 4), 13'(i * 1013), "R3");

    // single-bank precharge leaves others
    step(1'b1, 1'b0, 3'b010, 2'd0, 13'h400, "R6");
    step(1'b1, 1'b0, 3'b011, 2'd0, 13'h111, "R4");
    step(1'b1, 1'b0, 3'b011, 2'd3, 13'h1E0, "R4");
    step(1'b1, 1'b0, 3'b010, 2'd3, 13'h000, "R6");
    step(1'b1, 1'b0, 3'b100, 2'd0, 13'h0FF, "R5");

    // clock suspend with a bank open
    step(1'b1, 1'b0, 3'b011, 2'd1, 13'h0AB, "R4");
    step(1'b0, 1'b0, 3'b011, 2'd2, 13'h155, "R10");
    step(1'b0, 1'b0, 3'b101, 2'd1, 13'h033, "R10");
    step(1'b0, 1'b0, 3'b010, 2'd0, 13'h400, "R10");
    step(1'b1, 1'b0, 3'b101, 2'd2, 13'h1F5, "R10");

    // power-down with all idle
    step(1'b1, 1'b0, 3'b010, 2'd0, 13'h400, "R6");
    step(1'b0, 1'b0, 3'b111, 2'd0, 13'h0, "R11");
    step(1'b0, 1'b0, 3'b011, 2'd0, 13'h077, "R11");
    step(1'b0, 1'b1, 3'b000, 2'd0, 13'h0, "R11");
    step(1'b1, 1'b0, 3'b011, 2'd0, 13'h078, "R10");
    step(1'b0, 1'b0, 3'b011, 2'd3, 13'h099, "R11");
    step(1'b0, 1'b0, 3'b111, 2'd0, 13'h0, "R11");
    step(1'b1, 1'b0, 3'b111, 2'd0, 13'h0, "R11");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule